// File: doc/BRIEF.md
# Segment Address Translation Checker

This block turns a segment-relative address into a flat linear address and decides whether the access is allowed. It holds six segment registers: code, stack, data and three further data segments. Each register stores a base, a limit, a present flag and a code flag. A request names a segment, a byte offset, an access kind (read, write or fetch), an access size and a wide-mode flag. One cycle later the block returns either a linear address or a fault with a one-hot cause and the index of the faulting segment.

In legacy mode the base is added to the offset. The whole access must then fit inside the inclusive limit, and absent segments are refused. Wide mode gives a flat address space. The base is dropped for every segment except the two auxiliary ones, which keep adding their base. Limit and presence are not checked in wide mode. A plain write port loads one segment register per cycle. Descriptor fetch from memory, privilege transitions and paging lie outside the block.

Top module: `seg_xlate_top`

## Requirements
- R1: A request with `req_valid` high gives `rsp_valid` high on the next clock. In legacy mode a permitted access returns `rsp_lin` = segment base + `req_off`, modulo 2^32. With no request, every response output is zero on the next clock.
- R2: The legacy limit check is inclusive and covers the whole access. The access ends at `req_off` + 2^`req_size` − 1, where size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. This end is computed without wrap-around. If it exceeds the limit, the response is a limit fault, shown as `rsp_cause` bit 0.
- R3: A segment whose limit is all ones never gives a limit fault, for any offset and any size.
- R4: A write (`req_kind` = 1) to a segment whose code flag is set gives a write-to-code fault, shown as `rsp_cause` bit 1, in either mode. Read (0) and fetch (2) to that segment are allowed.
- R5: In legacy mode a segment whose present flag is clear faults on any access, shown as `rsp_cause` bit 2. Only one cause is reported, in this order of priority: absent first, then limit, then write-to-code.
- R6: In wide mode, segments 0 to 3 use a base of zero, so a permitted access returns `rsp_lin` = `req_off`.
- R7: In wide mode, segments 4 and 5 still return their stored base + `req_off`.
- R8: In wide mode, neither the limit nor the present flag is checked.
- R9: Reset clears all response outputs. After reset, every segment is present, has limit 0x0000_FFFF and base 0, and is marked as data. The exception is segment 0, which is marked as code with base 0xFFFF_0000, so a fetch at offset 0xFFF0 yields 0xFFFF_FFF0.
- R10: On a fault, `rsp_fault` is high, `rsp_cause` has exactly one bit set and `rsp_lin` is zero. `rsp_seg` always echoes the requested segment index.
- R11: A register write with `wr_en` takes effect from the next clock. A request in the same cycle sees the old contents. A write to index 6 or 7 changes nothing.
- R12: A request to segment index 6 or 7 gives an absent fault (cause bit 2) in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 3 | Segment index of the request |
| req_off | input | 32 | Byte offset within the segment |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_size | input | 2 | Access size, 2^code bytes |
| req_wide | input | 1 | Wide (flat) mode for this request |
| wr_en | input | 1 | Segment register write strobe |
| wr_seg | input | 3 | Register index to load |
| wr_base | input | 32 | New base |
| wr_limit | input | 32 | New inclusive limit |
| wr_present | input | 1 | New present flag |
| wr_code | input | 1 | New code (read-only) flag |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 3 | One-hot cause: bit 0 limit, bit 1 write-to-code, bit 2 absent |
| rsp_seg | output | 3 | Requested segment index |
| rsp_lin | output | 32 | Linear address, zero on fault |

## Verification
A corrupted base, limit or flag in a segment register does not show up until that segment is next requested. At that request the response one cycle later shows a shifted `rsp_lin`, a missing or spurious limit fault, or a wrong absent or write-to-code cause. For this reason the stimulus requests every segment again after each register write. It also probes offsets one byte either side of each limit and repeats the requests in wide mode. A fault in the priority or the wide-mode gating shows up in the very next response as the wrong one-hot cause.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   localparam int CAUSE_W      = 3;
   localparam int CAUSE_LIMIT  = 0;
   localparam int CAUSE_WCODE  = 1;
   localparam int CAUSE_ABSENT = 2;
endpackage

// File: rtl/seg_regfile.sv
`timescale 1ns/1ps
module seg_regfile #(
   parameter int NSEG = 6,
   parameter int AW = 32,
   parameter int SEG_W = 3,
   parameter int CODE_IDX = 0,
   parameter logic [AW-1:0] RST_CODE_BASE = '0,
   parameter logic [AW-1:0] RST_LIMIT = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SEG_W-1:0] wr_seg,
   input  logic [AW-1:0] wr_base,
   input  logic [AW-1:0] wr_limit,
   input  logic          wr_present,
   input  logic          wr_code,
   output logic [AW-1:0] base_o [NSEG],
   output logic [AW-1:0] limit_o [NSEG],
   output logic          present_o [NSEG],
   output logic          code_o [NSEG]
);
   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam logic [AW-1:0] BASE0 = (g == CODE_IDX) ? RST_CODE_BASE : '0;
      localparam logic          CODE0 = (g == CODE_IDX);
      logic [AW-1:0] base_q;
      logic [AW-1:0] limit_q;
      logic          present_q;
      logic          code_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q    <= BASE0;
            limit_q   <= RST_LIMIT;
            present_q <= 1'b1;
            code_q    <= CODE0;
         end else if (wr_en && (wr_seg == SEG_W'(g))) begin
            base_q    <= wr_base;
            limit_q   <= wr_limit;
            present_q <= wr_present;
            code_q    <= wr_code;
         end
      end

      assign base_o[g]    = base_q;
      assign limit_o[g]   = limit_q;
      assign present_o[g] = present_q;
      assign code_o[g]    = code_q;
   end
endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int NSEG = 6,
   parameter int AW = 32,
   parameter int SEG_W = 3,
   parameter int AUX_A = 4,
   parameter int AUX_B = 5,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [SEG_W-1:0]   seg,
   input  logic [AW-1:0]      off,
   input  logic [1:0]         kind,
   input  logic [1:0]         size,
   input  logic               wide,
   input  logic [AW-1:0]      base_i [NSEG],
   input  logic [AW-1:0]      limit_i [NSEG],
   input  logic               present_i [NSEG],
   input  logic               code_i [NSEG],
   output logic               fault,
   output logic [CAUSE_W-1:0] cause,
   output logic [AW-1:0]      lin
);
   logic          hit;
   logic [AW-1:0] sel_base;
   logic [AW-1:0] sel_limit;
   logic          sel_present;
   logic          sel_code;
   logic          wide_act;
   logic          aux;
   logic [AW:0]   span_end;
   logic          over;
   logic          absent;
   logic          lim_f;
   logic          wc_f;

   // Variant: wide mode supported or tied off.
   if (WIDE_EN) begin : g_wide
      assign wide_act = wide;
   end else begin : g_legacy
      logic unused_wide;
      assign unused_wide = wide;
      assign wide_act = 1'b0;
   end

   always_comb begin
      hit = 1'b0;
      sel_base = '0;
      sel_limit = '0;
      sel_present = 1'b0;
      sel_code = 1'b0;
      for (int i = 0; i < NSEG; i++) begin
         if (seg == SEG_W'(i)) begin
            hit = 1'b1;
            sel_base = base_i[i];
            sel_limit = limit_i[i];
            sel_present = present_i[i];
            sel_code = code_i[i];
         end
      end
   end

   assign aux = (seg == SEG_W'(AUX_A)) || (seg == SEG_W'(AUX_B));
   assign lin = ((wide_act && !aux) ? '0 : sel_base) + off;

   // Inclusive end of the access, one extra bit so nothing wraps.
   assign span_end = {1'b0, off} + (AW+1)'((4'd1 << size) - 4'd1);
   assign over = (sel_limit != '1) && (span_end > {1'b0, sel_limit});

   assign absent = !hit || (!wide_act && !sel_present);
   assign lim_f  = !wide_act && over;
   assign wc_f   = (kind == ACC_WRITE) && sel_code;

   always_comb begin
      cause = '0;
      if (absent)     cause[CAUSE_ABSENT] = 1'b1;
      else if (lim_f) cause[CAUSE_LIMIT]  = 1'b1;
      else if (wc_f)  cause[CAUSE_WCODE]  = 1'b1;
   end

   assign fault = |cause;
endmodule

// File: rtl/seg_xlate_top.sv
`timescale 1ns/1ps
module seg_xlate_top
   import seg_xlate_pkg::*;
#(
   parameter int AW = 32,
   parameter int NSEG = 6,
   parameter int SEG_W = 3,
   parameter int AUX_A = 4,
   parameter int AUX_B = 5,
   parameter int CODE_IDX = 0,
   parameter bit WIDE_EN = 1'b1,
   parameter logic [AW-1:0] RST_CODE_BASE = AW'(32'hFFFF_0000),
   parameter logic [AW-1:0] RST_LIMIT = AW'(32'h0000_FFFF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [AW-1:0]      req_off,
   input  logic [1:0]         req_kind,
   input  logic [1:0]         req_size,
   input  logic               req_wide,
   input  logic               wr_en,
   input  logic [SEG_W-1:0]   wr_seg,
   input  logic [AW-1:0]      wr_base,
   input  logic [AW-1:0]      wr_limit,
   input  logic               wr_present,
   input  logic               wr_code,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [CAUSE_W-1:0] rsp_cause,
   output logic [SEG_W-1:0]   rsp_seg,
   output logic [AW-1:0]      rsp_lin
);
   initial begin
      if (AW < 8) $fatal(1, "AW too small");
      if (NSEG < 1 || NSEG > (1 << SEG_W)) $fatal(1, "NSEG does not fit SEG_W");
      if (AUX_A >= NSEG || AUX_B >= NSEG || AUX_A == AUX_B) $fatal(1, "bad auxiliary segments");
      if (CODE_IDX >= NSEG) $fatal(1, "bad code segment index");
   end

   logic [AW-1:0]      base_w [NSEG];
   logic [AW-1:0]      limit_w [NSEG];
   logic               present_w [NSEG];
   logic               code_w [NSEG];
   logic               fault_c;
   logic [CAUSE_W-1:0] cause_c;
   logic [AW-1:0]      lin_c;

   seg_regfile #(
      .NSEG(NSEG), .AW(AW), .SEG_W(SEG_W), .CODE_IDX(CODE_IDX),
      .RST_CODE_BASE(RST_CODE_BASE), .RST_LIMIT(RST_LIMIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_seg(wr_seg),
      .wr_base(wr_base), .wr_limit(wr_limit), .wr_present(wr_present),
      .wr_code(wr_code), .base_o(base_w), .limit_o(limit_w),
      .present_o(present_w), .code_o(code_w)
   );

   seg_check #(
      .NSEG(NSEG), .AW(AW), .SEG_W(SEG_W), .AUX_A(AUX_A), .AUX_B(AUX_B),
      .WIDE_EN(WIDE_EN)
   ) u_check (
      .seg(req_seg), .off(req_off), .kind(req_kind), .size(req_size),
      .wide(req_wide), .base_i(base_w), .limit_i(limit_w),
      .present_i(present_w), .code_i(code_w), .fault(fault_c),
      .cause(cause_c), .lin(lin_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_cause <= '0;
         rsp_seg   <= '0;
         rsp_lin   <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_fault <= req_valid && fault_c;
         rsp_cause <= req_valid ? cause_c : '0;
         rsp_seg   <= req_valid ? req_seg : '0;
         rsp_lin   <= (req_valid && !fault_c) ? lin_c : '0;
      end
   end
endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk #(
   parameter int AW = 32,
   parameter int NSEG = 6,
   parameter int SEG_W = 3,
   parameter int AUX_A = 4,
   parameter int AUX_B = 5,
   parameter bit WIDE_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [SEG_W-1:0] req_seg,
   input logic [AW-1:0]    req_off,
   input logic             req_wide,
   input logic             rsp_valid,
   input logic             rsp_fault,
   input logic [2:0]       rsp_cause,
   input logic [SEG_W-1:0] rsp_seg,
   input logic [AW-1:0]    rsp_lin
);
   logic seg_in_range;
   logic seg_flat;
   assign seg_in_range = ({1'b0, req_seg} < (SEG_W+1)'(NSEG));
   assign seg_flat = seg_in_range && (req_seg != SEG_W'(AUX_A)) && (req_seg != SEG_W'(AUX_B));

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_fault && rsp_lin == '0)); // R1
   AST_CAUSE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> ($countones(rsp_cause) == 1)); // R10
   AST_NO_CAUSE_WHEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_fault |-> (rsp_cause == '0)); // R10
   AST_NO_ADDR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_lin == '0)); // R10
   AST_SEG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_seg == $past(req_seg))); // R10
   AST_WIDE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (WIDE_EN && req_valid && req_wide && seg_flat) |=> (rsp_fault || rsp_lin == $past(req_off))); // R6
   AST_WIDE_NO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (WIDE_EN && req_valid && req_wide && seg_in_range) |=> (!rsp_cause[0] && !rsp_cause[2])); // R8
   AST_BAD_INDEX_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !seg_in_range) |=> rsp_cause[2]); // R12
endmodule

bind seg_xlate_top seg_xlate_chk #(
   .AW(AW), .NSEG(NSEG), .SEG_W(SEG_W), .AUX_A(AUX_A), .AUX_B(AUX_B), .WIDE_EN(WIDE_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
   .req_off(req_off), .req_wide(req_wide), .rsp_valid(rsp_valid),
   .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_seg(rsp_seg),
   .rsp_lin(rsp_lin)
);

// File: tb/seg_xlate_top_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_seg = '0;
   logic [31:0] req_off = '0;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_size = '0;
   logic        req_wide = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_seg = '0;
   logic [31:0] wr_base = '0;
   logic [31:0] wr_limit = '0;
   logic        wr_present = 1'b0;
   logic        wr_code = 1'b0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [2:0]  rsp_cause;
   logic [2:0]  rsp_seg;
   logic [31:0] rsp_lin;

   always #10 clk = ~clk;   // 50 MHz

   seg_xlate_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
      .req_off(req_off), .req_kind(req_kind), .req_size(req_size),
      .req_wide(req_wide), .wr_en(wr_en), .wr_seg(wr_seg), .wr_base(wr_base),
      .wr_limit(wr_limit), .wr_present(wr_present), .wr_code(wr_code),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .rsp_seg(rsp_seg), .rsp_lin(rsp_lin)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // Behavioural model of the segment registers (indices 6, 7 stay empty).
   longint unsigned m_base [8];
   longint unsigned m_lim [8];
   bit              m_pres [8];
   bit              m_code [8];

   bit              e_valid, e_fault;
   int unsigned     e_cause;
   int unsigned     e_seg;
   longint unsigned e_lin;

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin
         m_base[i] = 0;
         m_lim[i]  = (i < 6) ? 64'h0000_FFFF : 0;
         m_pres[i] = (i < 6);
         m_code[i] = 0;
      end
      m_base[0] = 64'hFFFF_0000;
      m_code[0] = 1;
   endtask

   task automatic predict(bit v, int unsigned s, longint unsigned off,
                          int unsigned k, int unsigned sz, bit w);
      bit absent, limf, wcf, aux;
      longint unsigned last, b;
      e_valid = v; e_fault = 0; e_cause = 0; e_seg = 0; e_lin = 0;
      if (v) begin
         aux    = (s == 4) || (s == 5);
         last   = off + (64'd1 << sz) - 1;
         absent = (s > 5) || (!w && !m_pres[s]);
         limf   = !w && (m_lim[s] != 64'hFFFF_FFFF) && (last > m_lim[s]);
         wcf    = (k == 1) && m_code[s];
         e_seg  = s;
         if (absent)    e_cause = 4;
         else if (limf) e_cause = 1;
         else if (wcf)  e_cause = 2;
         e_fault = (e_cause != 0);
         b = (w && !aux) ? 0 : m_base[s];
         if (!e_fault) e_lin = (b + off) & 64'hFFFF_FFFF;
      end
   endtask

   task automatic cmp(string tag, string what, longint unsigned act, longint unsigned exp, inout bit bad);
      if (act != exp) begin
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
         bad = 1;
      end
   endtask

   task automatic compare_all(string tag);
      bit bad = 0;
      n_vec++;
      cmp(tag, "rsp_valid", rsp_valid, e_valid, bad);
      cmp(tag, "rsp_fault", rsp_fault, e_fault, bad);
      cmp(tag, "rsp_cause", rsp_cause, e_cause, bad);
      cmp(tag, "rsp_seg", rsp_seg, e_seg, bad);
      cmp(tag, "rsp_lin", rsp_lin, e_lin, bad);
      if (bad) n_bad++;
   endtask

   // One clock: drive at the falling edge, compare at the next falling edge.
   task automatic step(string tag, bit v, int unsigned s, longint unsigned off,
                       int unsigned k, int unsigned sz, bit w,
                       bit we, int unsigned ws, longint unsigned wb,
                       longint unsigned wl, bit wp, bit wc);
      req_valid = v; req_seg = 3'(s); req_off = 32'(off); req_kind = 2'(k);
      req_size = 2'(sz); req_wide = w;
      wr_en = we; wr_seg = 3'(ws); wr_base = 32'(wb); wr_limit = 32'(wl);
      wr_present = wp; wr_code = wc;
      predict(v, s, off, k, sz, w);
      if (we && ws < 6) begin
         m_base[ws] = wb; m_lim[ws] = wl; m_pres[ws] = wp; m_code[ws] = wc;
      end
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic rd(string tag, int unsigned s, longint unsigned off,
                     int unsigned k, int unsigned sz, bit w);
      step(tag, 1, s, off, k, sz, w, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic wr(string tag, int unsigned s, longint unsigned b,
                     longint unsigned l, bit p, bit c);
      step(tag, 0, 0, 0, 0, 0, 0, 1, s, b, l, p, c);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R9: response outputs cleared during reset
      e_valid = 0; e_fault = 0; e_cause = 0; e_seg = 0; e_lin = 0;
      compare_all("R9");
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset fetch lands at the top of the space; data base is zero
      rd("R9", 0, 64'hFFF0, 2, 0, 0);
      rd("R9", 2, 64'h10, 0, 2, 0);
      // R1: idle cycle, then a plain read on the stack segment
      step("R1", 0, 3, 64'h55, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      rd("R1", 1, 64'h1234, 0, 1, 0);

      // R2: inclusive limit, whole access must fit
      rd("R2", 2, 64'hFFFF, 0, 0, 0);
      rd("R2", 2, 64'hFFFF, 0, 1, 0);
      rd("R2", 2, 64'hFFFC, 0, 2, 0);
      rd("R2", 2, 64'hFFFD, 0, 2, 0);
      rd("R2", 2, 64'hFFF8, 0, 3, 0);

      // R11: write and request in the same cycle; request sees the old base
      step("R11", 1, 2, 64'h20, 0, 0, 0, 1, 2, 64'h1000_0000, 64'h00FF_FFFF, 1, 0);
      rd("R11", 2, 64'h20, 0, 0, 0);
      wr("R11", 6, 64'hDEAD_0000, 64'hFFFF_FFFF, 1, 0);
      // R12: empty indices fault as absent in both modes
      rd("R12", 6, 64'h0, 0, 0, 0);
      rd("R12", 7, 64'h0, 0, 0, 1);

      // R4: write to code refused, read and fetch allowed
      rd("R4", 0, 64'h100, 1, 0, 0);
      rd("R4", 0, 64'h100, 0, 0, 0);
      rd("R4", 0, 64'h100, 1, 0, 1);

      // R3: full-space limit never faults, even at the top of the space
      wr("R3", 1, 64'h0, 64'hFFFF_FFFF, 1, 0);
      rd("R3", 1, 64'hFFFF_FFFF, 0, 3, 0);
      rd("R3", 1, 64'hFFFF_FFF0, 1, 2, 0);

      // R5: absent segment and cause priority
      wr("R5", 3, 64'h2000, 64'h0F, 0, 0);
      rd("R5", 3, 64'h4, 0, 0, 0);
      rd("R5", 3, 64'h100, 1, 0, 0);
      rd("R5", 0, 64'h1_0000, 1, 0, 0);

      // R6, R7, R8: wide mode
      rd("R6", 2, 64'h1234_5678, 0, 2, 1);
      rd("R6", 0, 64'hFFF0, 2, 0, 1);
      wr("R7", 4, 64'h4000_0000, 64'h0, 1, 0);
      rd("R7", 4, 64'h100, 0, 0, 1);
      wr("R7", 5, 64'hFFFF_F000, 64'h10, 1, 0);
      rd("R7", 5, 64'h2000, 1, 3, 1);
      rd("R8", 3, 64'h9999, 0, 0, 1);
      rd("R8", 4, 64'h100, 0, 0, 0);
      rd("R8", 2, 64'hFFFF_FFFF, 0, 3, 1);

      // R10: mixed traffic; every response field compared each cycle
      for (int i = 0; i < 400; i++) begin
         int unsigned s = $urandom_range(0, 7);
         longint unsigned lim = m_lim[s];
         longint unsigned off = ($urandom_range(0, 1) == 1)
                                ? ((lim + 64'($urandom_range(0, 8)) - 4) & 64'hFFFF_FFFF)
                                : 64'($urandom);
         bit we = ($urandom_range(0, 3) == 0);
         longint unsigned wl = ($urandom_range(0, 3) == 0) ? 64'hFFFF_FFFF
                               : 64'($urandom_range(0, 32'hFFFFF));
         step("R10", $urandom_range(0, 4) != 0, s, off, $urandom_range(0, 2),
              $urandom_range(0, 3), $urandom_range(0, 1) == 1,
              we, $urandom_range(0, 7), 64'($urandom), wl,
              $urandom_range(0, 5) != 0, $urandom_range(0, 2) == 0);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule